// File: doc/BRIEF.md
# Shared-Counter Time Base and Watchdog Interrupt

This block derives two slow timing signals from one counter chain. The first is a periodic time-base square wave. The second is a watchdog time-out flag. Either one can be routed to an interrupt pin that is modelled as a pull-down enable.

A source tick feeds the chain. The tick is either already at the 32 kHz base rate, or comes from a 256 kHz source and is first divided by 8. A rate divider then scales the base by a power of two that the 3-bit rate code selects. After that, a shared 8-stage counter forms the time base, and two further stages form the watchdog.

Decoded commands arrive as single-cycle strobes. They start and stop the shared counter, select what drives the interrupt, clear the stages, gate the interrupt and load the rate code. Because the time base and the watchdog share one counter, stopping or clearing one also affects the other.

A watchdog time-out is latched. It holds the interrupt pulled low until software clears the watchdog or disables the interrupt. With an internal source, dropping the system enable freezes every counter. With an external clock source, the system enable has no effect.

Top module: `tbase_wdog_irq`

## Requirements
- R1: After reset, `irq_pull` and `tb_out` are 0 and the counter is stopped. The interrupt is disabled, the time base is routed to the interrupt, and the rate code is 0. Starting the counter without loading a rate gives the code-0 period.
- R2: With `src_fast`=0 and a tick on every cycle, `tb_out` rises 2^(7-c) * 2^(TB_W-1) ticks after a clear, for rate code c. It then toggles every time that many ticks pass. Code 7 is the fastest and code 0 the slowest.
- R3: With `src_fast`=1, one base tick is taken for every 8 source ticks. All periods therefore become 8 times longer.
- R4: The watchdog flag sets 2^(7-c) * 2^(TB_W+WD_W) base ticks after a CLR WDT. This is 2^WD_W full wraps of the time-base counter.
- R5: WDT EN starts the counter and routes the watchdog flag to the interrupt. TIMER EN starts the counter and routes `tb_out` to the interrupt. While the time base is routed and the interrupt is enabled, `irq_pull` equals `tb_out`.
- R6: WDT DIS stops the shared counter. `tb_out` then holds and the watchdog cannot time out until an enable strobe restarts the count from where it stopped.
- R7: CLR WDT clears the divide-by-8 stage, the rate divider, the time-base counter, the watchdog stages and the watchdog flag. CLR TIMER clears all of these except the watchdog stages and the flag.
- R8: Once set, the watchdog flag keeps `irq_pull` at 1 until CLR WDT or IRQ DIS, while the watchdog is routed and the interrupt is enabled. The flag also latches while the interrupt is disabled and appears when the interrupt is next enabled.
- R9: IRQ DIS forces `irq_pull` to 0 (floating pin) and clears the watchdog flag. `irq_pull` stays 0 until IRQ EN.
- R10: With `sys_en`=0 and `ext_src`=0, no counter advances. With `ext_src`=1, `sys_en` has no effect.
- R11: When strobes coincide, clear and disable win over enable. WDT DIS with WDT EN leaves the counter stopped. IRQ DIS with IRQ EN leaves the interrupt disabled. A clear with an enable clears the stages, and counting starts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Source tick, one cycle wide |
| src_fast | input | 1 | 1: source is 256 kHz and is divided by 8 |
| ext_src | input | 1 | 1: external clock source, so the system enable is ignored |
| sys_en | input | 1 | System enable |
| cmd_wdt_en | input | 1 | Strobe: start the counter and route the watchdog |
| cmd_wdt_dis | input | 1 | Strobe: stop the shared counter |
| cmd_tmr_en | input | 1 | Strobe: start the counter and route the time base |
| cmd_clr_wdt | input | 1 | Strobe: clear all stages and the flag |
| cmd_clr_tmr | input | 1 | Strobe: clear the time-base stages |
| cmd_irq_en | input | 1 | Strobe: enable the interrupt output |
| cmd_irq_dis | input | 1 | Strobe: disable the interrupt output and clear the flag |
| cmd_rate | input | 1 | Strobe: load `rate_sel` |
| rate_sel | input | RATE_W | Rate code loaded by `cmd_rate` |
| irq_pull | output | 1 | Interrupt pull-down enable (1 = pin driven low) |
| tb_out | output | 1 | Time-base square wave |

## Verification
The assertions check the following on every cycle:
- `irq_pull` is 0 right after a disable strobe.
- `tb_out` is low right after either clear.
- `tb_out` holds while the counter is stopped or the system is halted.
- A latched time-out keeps pulling until it is released.

The exact tick counts per rate code and per source, the extra watchdog stages, and the watchdog stages surviving CLR TIMER can only be shown by the bench scenarios. The same holds for the outcome of coincident strobes, which the bench measures edge by edge.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

  typedef enum logic {
    ROUTE_TIMER = 1'b0,
    ROUTE_WDT   = 1'b1
  } route_e;

  typedef struct packed {
    logic wdt_en;
    logic wdt_dis;
    logic tmr_en;
    logic clr_wdt;
    logic clr_tmr;
    logic irq_en;
    logic irq_dis;
    logic rate_ld;
  } cmd_t;

endpackage

// File: rtl/tbw_prescale.sv
module tbw_prescale #(
  parameter int RATE_W = 3,
  parameter int FAST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              src_fast,
  input  logic              active,
  input  logic              clear,
  input  logic [RATE_W-1:0] rate,
  output logic              pre_tick
);
  localparam int DIV_W = (1 << RATE_W) - 1;
  localparam logic [FAST_W-1:0] FAST_ONE = 1;
  localparam logic [DIV_W-1:0]  DIV_ONE  = 1;
  localparam logic [DIV_W-1:0]  DIV_ALL  = '1;

  logic [FAST_W-1:0] fast_q, fast_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DIV_W-1:0]  mask;
  logic              src_step, base_tick;

  // fast source: take one base tick per 2^FAST_W source ticks
  always_comb begin
    src_step  = active && tick_in;
    base_tick = src_step && (!src_fast || (&fast_q));
    mask      = DIV_ALL >> rate;
    pre_tick  = base_tick && ((div_q & mask) == mask);
  end

  always_comb begin
    fast_d = fast_q;
    div_d  = div_q;
    if (clear) begin
      fast_d = '0;
      div_d  = '0;
    end else begin
      if (src_step && src_fast) fast_d = fast_q + FAST_ONE;
      if (base_tick)            div_d  = div_q + DIV_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= '0;
      div_q  <= '0;
    end else begin
      fast_q <= fast_d;
      div_q  <= div_d;
    end
  end
endmodule

// File: rtl/tbw_chain.sv
module tbw_chain #(
  parameter int TB_W = 8,
  parameter int WD_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_tick,
  input  logic clr_tb,
  input  logic clr_wd,
  input  logic flag_clr,
  output logic tb_level,
  output logic wd_flag
);
  localparam logic [TB_W-1:0] TB_ONE = 1;
  localparam logic [WD_W-1:0] WD_ONE = 1;

  logic [TB_W-1:0] tb_q, tb_d;
  logic [WD_W-1:0] wd_q, wd_d;
  logic            flag_q, flag_d;
  logic            tb_wrap, wd_wrap;

  always_comb begin
    tb_wrap = pre_tick && (&tb_q);
    wd_wrap = tb_wrap && (&wd_q);

    tb_d = tb_q;
    if (clr_tb || clr_wd)  tb_d = '0;
    else if (pre_tick)     tb_d = tb_q + TB_ONE;

    wd_d = wd_q;
    if (clr_wd)            wd_d = '0;
    else if (tb_wrap)      wd_d = wd_q + WD_ONE;

    flag_d = flag_q;
    if (clr_wd || flag_clr) flag_d = 1'b0;
    else if (wd_wrap)       flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q   <= '0;
      wd_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      tb_q   <= tb_d;
      wd_q   <= wd_d;
      flag_q <= flag_d;
    end
  end

  assign tb_level = tb_q[TB_W-1];
  assign wd_flag  = flag_q;
endmodule

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
  import tbw_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              run,
  output route_e            route,
  output logic              irq_on,
  output logic [RATE_W-1:0] rate
);
  logic              run_q, run_d;
  route_e            route_q, route_d;
  logic              irq_q, irq_d;
  logic [RATE_W-1:0] rate_q, rate_d;

  always_comb begin
    run_d = run_q;
    if (cmd.wdt_dis)                    run_d = 1'b0;
    else if (cmd.wdt_en || cmd.tmr_en)  run_d = 1'b1;

    route_d = route_q;
    if (cmd.tmr_en)      route_d = ROUTE_TIMER;
    else if (cmd.wdt_en) route_d = ROUTE_WDT;

    irq_d = irq_q;
    if (cmd.irq_dis)     irq_d = 1'b0;
    else if (cmd.irq_en) irq_d = 1'b1;

    rate_d = rate_q;
    if (cmd.rate_ld)     rate_d = rate_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      route_q <= ROUTE_TIMER;
      irq_q   <= 1'b0;
      rate_q  <= '0;
    end else begin
      run_q   <= run_d;
      route_q <= route_d;
      irq_q   <= irq_d;
      rate_q  <= rate_d;
    end
  end

  assign run    = run_q;
  assign route  = route_q;
  assign irq_on = irq_q;
  assign rate   = rate_q;
endmodule

// File: rtl/tbase_wdog_irq.sv
module tbase_wdog_irq
  import tbw_pkg::*;
#(
  parameter int RATE_W = 3,
  parameter int FAST_W = 3,
  parameter int TB_W   = 8,
  parameter int WD_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              src_fast,
  input  logic              ext_src,
  input  logic              sys_en,
  input  logic              cmd_wdt_en,
  input  logic              cmd_wdt_dis,
  input  logic              cmd_tmr_en,
  input  logic              cmd_clr_wdt,
  input  logic              cmd_clr_tmr,
  input  logic              cmd_irq_en,
  input  logic              cmd_irq_dis,
  input  logic              cmd_rate,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              irq_pull,
  output logic              tb_out
);
  cmd_t              cmd;
  logic              run_q;
  route_e            route_q;
  logic              irq_on;
  logic [RATE_W-1:0] rate_q;
  logic              active, pre_tick, any_clr, tb_level, wd_flag;
  logic              route_wdt;

  always_comb begin
    cmd.wdt_en  = cmd_wdt_en;
    cmd.wdt_dis = cmd_wdt_dis;
    cmd.tmr_en  = cmd_tmr_en;
    cmd.clr_wdt = cmd_clr_wdt;
    cmd.clr_tmr = cmd_clr_tmr;
    cmd.irq_en  = cmd_irq_en;
    cmd.irq_dis = cmd_irq_dis;
    cmd.rate_ld = cmd_rate;
  end

  tbw_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .rate_sel (rate_sel),
    .run      (run_q),
    .route    (route_q),
    .irq_on   (irq_on),
    .rate     (rate_q)
  );

  // the external source ignores the system enable
  assign active  = run_q && (sys_en || ext_src);
  assign any_clr = cmd_clr_wdt || cmd_clr_tmr;

  tbw_prescale #(.RATE_W(RATE_W), .FAST_W(FAST_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .src_fast (src_fast),
    .active   (active),
    .clear    (any_clr),
    .rate     (rate_q),
    .pre_tick (pre_tick)
  );

  tbw_chain #(.TB_W(TB_W), .WD_W(WD_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_tick (pre_tick),
    .clr_tb   (cmd_clr_tmr),
    .clr_wd   (cmd_clr_wdt),
    .flag_clr (cmd_irq_dis),
    .tb_level (tb_level),
    .wd_flag  (wd_flag)
  );

  assign route_wdt = (route_q == ROUTE_WDT);
  assign tb_out    = tb_level;
  assign irq_pull  = irq_on && (route_wdt ? wd_flag : tb_level);
endmodule

// File: rtl/tbw_checker.sv
module tbw_checker (
  input logic clk,
  input logic rst_n,
  input logic sys_en,
  input logic ext_src,
  input logic cmd_clr_wdt,
  input logic cmd_clr_tmr,
  input logic cmd_irq_dis,
  input logic cmd_tmr_en,
  input logic run_q,
  input logic route_wdt,
  input logic irq_pull,
  input logic tb_out
);
  AST_DIS_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_irq_dis |=> !irq_pull); // R9

  AST_CLR_WDT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_wdt |=> (!tb_out && !irq_pull)); // R7

  AST_CLR_TMR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_tmr |=> !tb_out); // R7

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_en && !ext_src && !cmd_clr_wdt && !cmd_clr_tmr) |=> $stable(tb_out)); // R10

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd_clr_wdt && !cmd_clr_tmr) |=> $stable(tb_out)); // R6

  AST_LATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pull && route_wdt && !cmd_clr_wdt && !cmd_irq_dis && !cmd_tmr_en) |=> irq_pull); // R8
endmodule

bind tbase_wdog_irq tbw_checker u_tbw_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_en      (sys_en),
  .ext_src     (ext_src),
  .cmd_clr_wdt (cmd_clr_wdt),
  .cmd_clr_tmr (cmd_clr_tmr),
  .cmd_irq_dis (cmd_irq_dis),
  .cmd_tmr_en  (cmd_tmr_en),
  .run_q       (run_q),
  .route_wdt   (route_wdt),
  .irq_pull    (irq_pull),
  .tb_out      (tb_out)
);

// File: tb/test_tbase_wdog_irq.sv
module test_tbase_wdog_irq;
  localparam int TB_W = 4;
  localparam int WD_W = 2;
  localparam int RATE_W = 3;

  // strobe bit positions in the bench command word
  localparam logic [7:0] C_WEN = 8'h01, C_WDIS = 8'h02, C_TEN = 8'h04, C_CLW = 8'h08,
                         C_CLT = 8'h10, C_IEN = 8'h20, C_IDIS = 8'h40, C_RATE = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_in = 1'b1;
  logic src_fast = 1'b0;
  logic ext_src = 1'b0;
  logic sys_en = 1'b1;
  logic [7:0] cmd = '0;
  logic [RATE_W-1:0] rate_sel = '0;
  logic irq_pull, tb_out;
  int vectors = 0;
  int fails = 0;
  bit done = 0;
  int n;

  always #10 clk = ~clk;

  tbase_wdog_irq #(.RATE_W(RATE_W), .FAST_W(3), .TB_W(TB_W), .WD_W(WD_W)) i_tbase_wdog_irq (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .src_fast(src_fast), .ext_src(ext_src),
    .sys_en(sys_en), .cmd_wdt_en(cmd[0]), .cmd_wdt_dis(cmd[1]), .cmd_tmr_en(cmd[2]),
    .cmd_clr_wdt(cmd[3]), .cmd_clr_tmr(cmd[4]), .cmd_irq_en(cmd[5]), .cmd_irq_dis(cmd[6]),
    .cmd_rate(cmd[7]), .rate_sel(rate_sel), .irq_pull(irq_pull), .tb_out(tb_out));

  function automatic int half_ticks(input int c, input bit fast);
    return (1 << (7 - c)) * (1 << (TB_W - 1)) * (fast ? 8 : 1);
  endfunction

  function automatic int wdt_ticks(input int c, input bit fast);
    return (1 << (7 - c)) * (1 << (TB_W + WD_W)) * (fast ? 8 : 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; the strobe is sampled at the next posedge
  task automatic strobe(input logic [7:0] m);
    cmd = m;
    @(negedge clk);
    cmd = '0;
  endtask

  task automatic run(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_for(input bit on_irq, input logic lvl, input int lim, output int cnt);
    cnt = -1;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if ((on_irq ? irq_pull : tb_out) === lvl) begin
        cnt = k;
        break;
      end
    end
  endtask

  task automatic set_rate(input int c);
    rate_sel = RATE_W'(c);
    strobe(C_RATE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and stopped counter
    chk("R1 tb_out at reset", tb_out, 0);
    chk("R1 irq_pull at reset", irq_pull, 0);
    run(300);
    chk("R1 counter stopped", tb_out, 0);
    strobe(C_TEN);
    wait_for(0, 1'b1, 5000, n);
    chk("R1 default rate code 0", n, half_ticks(0, 0));

    // R2 / R5 sweep over every rate code, time base routed
    strobe(C_IEN);
    for (int c = 0; c < 8; c++) begin
      set_rate(c);
      strobe(C_CLW);
      wait_for(0, 1'b1, 5000, n);
      chk($sformatf("R2 rise code %0d", c), n, half_ticks(c, 0));
      chk($sformatf("R5 irq follows tb code %0d", c), irq_pull, 1);
      wait_for(0, 1'b0, 5000, n);
      chk($sformatf("R2 fall code %0d", c), n, half_ticks(c, 0));
      chk($sformatf("R5 irq low code %0d", c), irq_pull, 0);
    end

    // R3 fast source divided by 8
    src_fast = 1'b1;
    for (int c = 5; c < 8; c++) begin
      set_rate(c);
      strobe(C_CLW);
      wait_for(0, 1'b1, 5000, n);
      chk($sformatf("R3 fast rise code %0d", c), n, half_ticks(c, 1));
    end
    src_fast = 1'b0;

    // R4 watchdog time-out, watchdog routed
    strobe(C_WEN);
    for (int c = 5; c < 8; c++) begin
      set_rate(c);
      strobe(C_CLW);
      wait_for(1, 1'b1, 5000, n);
      chk($sformatf("R4 wdt time-out code %0d", c), n, wdt_ticks(c, 0));
    end

    // R8 latch held, then released by CLR WDT
    run(200);
    chk("R8 latched pull held", irq_pull, 1);
    strobe(C_CLW);
    chk("R8 CLR WDT releases", irq_pull, 0);

    // R7 CLR TIMER keeps watchdog stages (code 7)
    run(40);
    chk("R7 tb_out high mid-count", tb_out, 1);
    strobe(C_CLT);
    chk("R7 CLR TIMER zeroes tb", tb_out, 0);
    wait_for(1, 1'b1, 5000, n);
    chk("R7 wdt stages kept", n, wdt_ticks(7, 0) - 2 * (1 << TB_W));

    // R9 IRQ DIS floats the pin
    strobe(C_IDIS);
    chk("R9 IRQ DIS floats", irq_pull, 0);
    run(200);
    chk("R9 stays floating", irq_pull, 0);
    // R11 IRQ EN with IRQ DIS leaves it disabled
    strobe(C_IEN | C_IDIS);
    run(300);
    chk("R11 dis wins over en", irq_pull, 0);
    strobe(C_IEN);
    chk("R8 flag latched while disabled", irq_pull, 1);

    // R6 WDT DIS stops the shared counter
    strobe(C_TEN);
    strobe(C_CLW);
    run(5);
    strobe(C_WDIS);
    run(100);
    chk("R6 stopped tb_out", tb_out, 0);
    strobe(C_WEN);
    wait_for(0, 1'b1, 5000, n);
    chk("R6 resumes from held count", n, 2);

    // R10 halt with internal source
    strobe(C_TEN);
    strobe(C_CLW);
    run(4);
    sys_en = 1'b0;
    run(100);
    chk("R10 halted tb_out", tb_out, 0);
    sys_en = 1'b1;
    wait_for(0, 1'b1, 5000, n);
    chk("R10 resume after halt", n, 4);
    // R10 external source ignores sys_en
    ext_src = 1'b1;
    sys_en = 1'b0;
    strobe(C_CLW);
    wait_for(0, 1'b1, 5000, n);
    chk("R10 external source runs", n, half_ticks(7, 0));
    sys_en = 1'b1;
    ext_src = 1'b0;

    // R11 disable wins over enable, clear with enable
    strobe(C_CLW | C_WEN | C_WDIS);
    run(100);
    chk("R11 wdt dis wins", tb_out, 0);
    strobe(C_CLW | C_TEN);
    wait_for(0, 1'b1, 5000, n);
    chk("R11 clear with enable", n, half_ticks(7, 0));

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule